// File: doc/BRIEF.md
# Pin Event Interrupt Unit

This block watches 32 general-purpose pins, arranged as four groups of eight, and raises one interrupt request line for each pin. Pin `g*8 + b` (group `g`, bit `b`) is source `n`. It drives `irq[n]`, and the interrupt controller places that line at platform ID `n + 8`. Each source can be set to react to a rising edge, a falling edge, a high level or a low level. Every pin passes through a two-flop synchroniser before any detection takes place.

Detected events are latched in a pending register. A source whose pending bit is set raises its request line unless its mask bit is set. Software clears pending bits by writing ones to a dedicated clear register. The same register port also holds an output value and a direction setting for every pin.

The register port is a single-cycle write strobe plus a read strobe. Read data is registered and is valid on the cycle after `rd_en`.

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous reset, the following all read as zero, and `irq`, `pin_out` and `pin_dir` are all zero:
  - every register;
  - the enable register.
- R2: Group `g` has a value register at byte address `g*8` and a direction register at `g*8+4`, each 8 bits wide.
  - `pin_out` and `pin_dir` reflect these registers. In the direction register, 1 means input.
  - A read of the value register returns the synchronised pin for input bits and the written value for output bits.
- R3: The interrupt registers sit at fixed addresses, each 32 bits wide, with bit `n` belonging to source `n = g*8+b` and driving `irq[n]`:

  | Address | Register |
  |---------|----------|
  | 0x40 | enable |
  | 0x44 | mask |
  | 0x48 | trigger |
  | 0x4C | polarity |
  | 0x50 | pending |
  | 0x54 | clear |

- R4: Edge mode is selected by trigger bit = 1. With polarity 1, a rising edge sets the pending bit; with polarity 0, a falling edge sets it. The opposite edge does not set it, and the bit stays set until it is cleared.
- R5: Level mode is selected by trigger bit = 0. With polarity 1, a high level sets the pending bit; with polarity 0, a low level sets it. While the level persists, the bit sets again after a clear.
- R6: A source whose enable bit is 0 never sets its pending bit, whatever its pin does.
- R7: `irq[n]` equals pending AND NOT mask. A masked event is still recorded in the pending register, and the request line rises once the mask bit is dropped.
- R8: Writing 1 to a bit of the clear register drops that pending bit. Bits written 0 are untouched, and the clear register reads back as zero.
- R9: A write to the pending register changes nothing.
- R10: If a set and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R11: A pin change made between two clock edges appears in pending and on `irq` at the third rising edge after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous pin levels, source `n` on bit `n` |
| pin_out | output | 32 | Output value for each pin |
| pin_dir | output | 32 | Direction for each pin, 1 = input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 32 | Interrupt request, one line per source |

## Verification
A wrong internal state shows up at the ports in one of two ways.

- **Bad detection state.** A stuck synchroniser or previous-value flop, or a wrong trigger or polarity decode, leaves a pending bit unset, or sets it on the wrong edge. This is visible on `irq` exactly three edges after the pin moves, and in the pending register on the following read.
- **Bad pending update.** Losing a set against a clear, clearing more bits than were written, or accepting writes to pending shows up on the very next edge as a request line that drops or stays high.

Because `irq` has no register behind the pending flops, a wrong mask bit shows up on the cycle right after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register map: group banks at stride 8, interrupt block at 0x40
  localparam int unsigned GRP_STRIDE = 8;
  localparam int unsigned OFS_VAL    = 0;
  localparam int unsigned OFS_DIR    = 4;
  localparam int unsigned ADR_EN     = 'h40;
  localparam int unsigned ADR_MASK   = 'h44;
  localparam int unsigned ADR_TRIG   = 'h48;
  localparam int unsigned ADR_POL    = 'h4C;
  localparam int unsigned ADR_PEND   = 'h50;
  localparam int unsigned ADR_CLR    = 'h54;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser followed by a previous-value flop for edge detection.
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] p
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      s      <= '0;
      p      <= '0;
    end else begin
      meta_q <= d;
      s      <= meta_q;
      p      <= s;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-source condition select and pending latch; a set beats a clear.
module gpio_irq_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] s,
  input  logic [N-1:0] p,
  input  logic [N-1:0] en,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr_hit,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise, fall, lvl, cond;

    assign rise = s[i] & ~p[i];
    assign fall = ~s[i] & p[i];
    assign lvl  = pol[i] ? s[i] : ~s[i];
    assign cond = trig[i] ? (pol[i] ? rise : fall) : lvl;
    assign set_vec[i] = en[i] & cond;

    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= set_vec[i] | (pend[i] & ~clr_hit[i]);
    end
  end
endmodule

// File: rtl/gpio_regs.sv
// Register file: per-group value/direction banks plus interrupt controls.
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned GRP_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N     = N_GRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      s,
  input  logic [N-1:0]      pend,
  output logic [DATA_W-1:0] rdata,
  output logic [N-1:0]      val_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      clr_hit
);
  logic [N-1:0]      pin_rd;
  logic [DATA_W-1:0] rd_mux;

  assign pin_rd  = (s & dir_q) | (val_q & ~dir_q);
  assign clr_hit = (wr_en && addr == ADDR_W'(ADR_CLR)) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < int'(N_GRP); g++) begin
        if (addr == ADDR_W'(g * GRP_STRIDE + OFS_VAL))
          val_q[g*GRP_W +: GRP_W] <= wdata[GRP_W-1:0];
        if (addr == ADDR_W'(g * GRP_STRIDE + OFS_DIR))
          dir_q[g*GRP_W +: GRP_W] <= wdata[GRP_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      trig_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_EN))   en_q   <= wdata[N-1:0];
      if (addr == ADDR_W'(ADR_MASK)) mask_q <= wdata[N-1:0];
      if (addr == ADDR_W'(ADR_TRIG)) trig_q <= wdata[N-1:0];
      if (addr == ADDR_W'(ADR_POL))  pol_q  <= wdata[N-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < int'(N_GRP); g++) begin
      if (addr == ADDR_W'(g * GRP_STRIDE + OFS_VAL))
        rd_mux[GRP_W-1:0] = pin_rd[g*GRP_W +: GRP_W];
      if (addr == ADDR_W'(g * GRP_STRIDE + OFS_DIR))
        rd_mux[GRP_W-1:0] = dir_q[g*GRP_W +: GRP_W];
    end
    if (addr == ADDR_W'(ADR_EN))   rd_mux[N-1:0] = en_q;
    if (addr == ADDR_W'(ADR_MASK)) rd_mux[N-1:0] = mask_q;
    if (addr == ADDR_W'(ADR_TRIG)) rd_mux[N-1:0] = trig_q;
    if (addr == ADDR_W'(ADR_POL))  rd_mux[N-1:0] = pol_q;
    if (addr == ADDR_W'(ADR_PEND)) rd_mux[N-1:0] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned GRP_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N     = N_GRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_dir,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N-1:0]      irq
);
  logic [N-1:0] s_vec, p_vec;
  logic [N-1:0] en_q, mask_q, trig_q, pol_q, clr_hit;
  logic [N-1:0] set_vec, pend_q;

  gpio_sync #(.W(N)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .s(s_vec), .p(p_vec)
  );

  gpio_regs #(
    .N_GRP(N_GRP), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .s(s_vec), .pend(pend_q), .rdata(rdata),
    .val_q(pin_out), .dir_q(pin_dir), .en_q(en_q), .mask_q(mask_q),
    .trig_q(trig_q), .pol_q(pol_q), .clr_hit(clr_hit)
  );

  gpio_irq_detect #(.N(N)) det_i (
    .clk(clk), .rst(rst), .s(s_vec), .p(p_vec), .en(en_q),
    .trig(trig_q), .pol(pol_q), .clr_hit(clr_hit),
    .set_vec(set_vec), .pend(pend_q)
  );

  // Request lines come straight from the pending and mask flops
  assign irq = pend_q & ~mask_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] irq,
  input logic [N-1:0] pend,
  input logic [N-1:0] en,
  input logic [N-1:0] clr_hit,
  input logic [N-1:0] set_vec
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq == '0)); // R1

  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(en)) == '0)); // R6

  AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((~pend & $past(pend) & ~$past(clr_hit)) == '0)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((pend & $past(set_vec)) == $past(set_vec))); // R10
endmodule

bind gpio_irq_unit gpio_irq_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .irq(irq), .pend(pend_q), .en(en_q),
  .clr_hit(clr_hit), .set_vec(set_vec)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb_top;
  localparam logic [7:0] A_EN = 8'h40, A_MASK = 8'h44, A_TRIG = 8'h48;
  localparam logic [7:0] A_POL = 8'h4C, A_PEND = 8'h50, A_CLR = 8'h54;

  // {src[4:0], trig, pol, start, end, expected pending}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {5'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 rising edge
    {5'd3,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 wrong edge
    {5'd12, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R4 falling edge
    {5'd12, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd20, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 high level
    {5'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd31, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 low level
    {5'd31, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_dir, rdata, irq;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out),
    .pin_dir(pin_dir), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_EN, '0); wr(A_MASK, '0); wr(A_CLR, '1);
    @(negedge clk); pin_in = '0;
    wait_n(4);
    wr(A_CLR, '1);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_EN, d);   chk("R1 enable", d, '0);
    rd(A_PEND, d); chk("R1 pending", d, '0);
    rd(8'h18, d);  chk("R1 value D", d, '0);
    chk("R1 outputs", irq | pin_out | pin_dir, '0);

    // Vector table: R3 source numbering, R4 edge, R5 level
    for (int k = 0; k < NV; k++) begin
      logic [4:0] src;
      src = VEC[k][9:5];
      quiesce();
      @(negedge clk); pin_in[src] = VEC[k][2];
      wait_n(4);
      wr(A_TRIG, 32'(VEC[k][4]) << src);
      wr(A_POL,  32'(VEC[k][3]) << src);
      wr(A_EN,   32'd1 << src);
      @(negedge clk); pin_in[src] = VEC[k][1];
      wait_n(4);
      rd(A_PEND, d);
      chk($sformatf("R3 R4 R5 row %0d", k), 32'(d[src]), 32'(VEC[k][0]));
      chk($sformatf("R3 R7 irq row %0d", k), 32'(irq[src]), 32'(VEC[k][0]));
    end

    // R11 latency, rising edge on source 5
    quiesce();
    wr(A_TRIG, '1); wr(A_POL, '1); wr(A_EN, 32'h60);
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R11 not at 2nd edge", 32'(irq[5]), 32'd0);
    @(negedge clk); chk("R11 at 3rd edge", 32'(irq[5]), 32'd1);

    // R10 set and clear on the same edge, source 6
    @(negedge clk); pin_in[6] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = A_CLR; wdata = 32'h40;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 set wins", 32'(irq[6]), 32'd1);
    wr(A_CLR, 32'h40);
    chk("R4 edge held off after clear", 32'(irq[6]), 32'd0);

    // R7 mask and R8 clear, sources 4 and 7
    quiesce();
    wr(A_TRIG, '1); wr(A_POL, '1); wr(A_EN, 32'h90); wr(A_MASK, 32'h80);
    @(negedge clk); pin_in[4] = 1'b1; pin_in[7] = 1'b1;
    wait_n(4);
    chk("R7 masked line low", irq & 32'h90, 32'h10);
    rd(A_PEND, d); chk("R7 masked event recorded", d & 32'h90, 32'h90);
    wr(A_MASK, '0);
    chk("R7 unmask raises line", irq & 32'h90, 32'h90);
    wr(A_CLR, 32'h80);
    chk("R8 only written bit cleared", irq & 32'h90, 32'h10);
    rd(A_CLR, d); chk("R8 clear reads zero", d, '0);

    // R5 level re-asserts after clear
    quiesce();
    wr(A_TRIG, '0); wr(A_POL, '1); wr(A_EN, 32'h0010_0000);
    @(negedge clk); pin_in[20] = 1'b1;
    wait_n(4);
    wr(A_CLR, 32'h0010_0000);
    wait_n(2);
    chk("R5 level re-asserts", 32'(irq[20]), 32'd1);
    @(negedge clk); pin_in[20] = 1'b0;
    wait_n(4);
    wr(A_CLR, 32'h0010_0000);
    wait_n(2);
    chk("R5 level gone stays clear", 32'(irq[20]), 32'd0);

    // R6 disabled source
    quiesce();
    wr(A_TRIG, '1); wr(A_POL, '1);
    @(negedge clk); pin_in[9] = 1'b1;
    wait_n(4);
    rd(A_PEND, d); chk("R6 disabled no pending", d, '0);

    // R9 write to pending ignored
    wr(A_PEND, '1);
    rd(A_PEND, d); chk("R9 pending write ignored", d, '0);
    chk("R9 irq stays low", irq, '0);

    // R2 value and direction, group B
    wr(8'h08, 32'hA5); wr(8'h0C, 32'h0F);
    chk("R2 pin_out", 32'(pin_out[15:8]), 32'hA5);
    chk("R2 pin_dir", 32'(pin_dir[15:8]), 32'h0F);
    @(negedge clk); pin_in[15:8] = 8'h3C;
    wait_n(3);
    rd(8'h08, d); chk("R2 mixed value read", d, 32'hAC);
    rd(8'h0C, d); chk("R2 direction read", d, 32'h0F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule